// File: doc/BRIEF.md
# Interrupt Enable, Status and Clear Unit

This block gathers a set of single-bit interrupt sources into one interrupt request line. Each source has a sticky status bit that is set whenever the source input is seen high on a clock edge. The bit stays set until software clears it, and a source that is already set cannot signal a second time until that happens. Software controls which sources may drive the request line through an enable register. The register uses J-K semantics: one 32-bit write carries a set field in its low half and a reset field in its high half, so enables can be changed without a read-modify-write.

Software reaches the block through a small synchronous register port. The port has a write strobe with an address and a data word, and a read strobe with an address whose data appears one cycle later. Address 0 is the enable register, address 1 is the status register and address 2 is the clear register. By default there are sixteen sources. Source 15 is the user request and source 14 is the acquisition-done event.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After synchronous reset, all enables and all status bits are 0, `irq_o` is 0 and `rd_data` is 0.
- R2: A write to address 0 with a 1 in data bit i (i below the source count) enables source i. A 1 in data bit 16+i disables source i. A source whose two bits are both 0 keeps its enable unchanged.
- R3: A write to address 0 with both bit i and bit 16+i at 1 inverts the enable of source i.
- R4: With the default sixteen sources, writing bit 31 of address 0 disables the user source (index 15) and writing bit 30 disables the acquisition-done source (index 14). The other enables are untouched.
- R5: A source input that is high on any clock edge sets its status bit. The bit stays 1 until it is cleared, whatever the input does afterwards.
- R6: A write to address 2 with a 1 in data bit i clears status bit i, and 0 bits leave status unchanged. After the clear, a new high input on that source sets the bit again.
- R7: If a source input is high on the same edge as a write that clears its status bit, the status bit stays 1.
- R8: `irq_o` is a register. One cycle after an edge, it is 1 exactly when some source was both enabled and set in status before that edge.
- R9: With `rd_en` high on an edge, `rd_data` after that edge holds the pre-edge enable vector (address 0), status vector (address 1) or zero (addresses 2 and 3), zero-extended. With `rd_en` low, `rd_data` holds its value.
- R10: Writes to address 1 and address 3 change neither the enables nor the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 enable, 1 status, 2 clear) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| src_pulse | input | NUM_SRC | Source request inputs, sampled each edge |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that the strobes, addresses and source inputs are known values on every clock edge after reset, and that a write and a source event may fall on the same edge. The bench drives every input from fully defined `$urandom` values at the falling edge. It draws sparse source pulses and writes that often hit set and reset bits of the same source together, and it also steers writes to the status and unused addresses. This keeps all stimulus within those conditions while still reaching the toggle and clear-collision cases.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_DW = 32;
  localparam int HALF_DW = REG_DW / 2;

  typedef enum logic [1:0] {
    RADDR_ENABLE = 2'd0,
    RADDR_STATUS = 2'd1,
    RADDR_CLEAR  = 2'd2,
    RADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_enable_jk.sv
module irq_enable_jk #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic [NUM_SRC-1:0] rst_bits,
  output logic [NUM_SRC-1:0] enable
);
  // J-K flip-flop per source: J = set, K = reset
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_jk
    always_ff @(posedge clk) begin
      if (rst) begin
        enable[g] <= 1'b0;
      end else if (we) begin
        enable[g] <= (set_bits[g] & ~enable[g]) | (~rst_bits[g] & enable[g]);
      end
    end
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(enable)); // R2

  AST_EN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (we && ((set_bits & rst_bits) != '0)) |=>
      ((enable & $past(set_bits & rst_bits)) == (~$past(enable) & $past(set_bits & rst_bits)))); // R3

  AST_EN_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    (we && ((rst_bits & ~set_bits) != '0)) |=>
      ((enable & $past(rst_bits & ~set_bits)) == '0)); // R2
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] status
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic drop;
    assign drop = clr_we & clr_bits[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        status[g] <= 1'b0;
      end else if (src[g]) begin
        status[g] <= 1'b1;            // new event beats a clear
      end else if (drop) begin
        status[g] <= 1'b0;
      end
    end
  end

  AST_ST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status & $past(status)) == $past(status))); // R5

  AST_ST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> ((status & $past(src)) == $past(src))); // R7

  AST_ST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status & $past(clr_bits & ~src)) == '0)); // R6
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic               rd_en,
  input  logic [1:0]         rd_addr,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] status,
  output logic               en_we,
  output logic               clr_we,
  output logic [REG_DW-1:0]  rd_data
);
  localparam int PAD = REG_DW - NUM_SRC;

  logic [REG_DW-1:0] rd_mux;

  assign en_we  = wr_en && (reg_addr_e'(wr_addr) == RADDR_ENABLE);
  assign clr_we = wr_en && (reg_addr_e'(wr_addr) == RADDR_CLEAR);

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      RADDR_ENABLE: rd_mux = {{PAD{1'b0}}, enable};
      RADDR_STATUS: rd_mux = {{PAD{1'b0}}, status};
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R9

  AST_RD_STATUS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 2'd1) |=> (rd_data == {{PAD{1'b0}}, $past(status)})); // R9

  AST_WR_DECODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_we, clr_we})); // R10
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [1:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_pulse,
  output logic               irq_o
);
  if (NUM_SRC < 1 || NUM_SRC > HALF_DW) begin : g_bad_cfg
    initial $error("NUM_SRC must be between 1 and %0d", HALF_DW);
  end

  logic               en_we;
  logic               clr_we;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] status;

  irq_reg_port #(.NUM_SRC(NUM_SRC)) u_port (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .enable  (enable),
    .status  (status),
    .en_we   (en_we),
    .clr_we  (clr_we),
    .rd_data (rd_data)
  );

  irq_enable_jk #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk      (clk),
    .rst      (rst),
    .we       (en_we),
    .set_bits (wr_data[NUM_SRC-1:0]),
    .rst_bits (wr_data[HALF_DW +: NUM_SRC]),
    .enable   (enable)
  );

  irq_status_latch #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .src      (src_pulse),
    .clr_we   (clr_we),
    .clr_bits (wr_data[NUM_SRC-1:0]),
    .status   (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |(status & enable);
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) == '0) |=> !irq_o); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) != '0) |=> irq_o); // R8
endmodule

// File: tb/irq_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_unit_tb_top;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NS-1:0] src_pulse = '0;
  logic          irq_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [NS-1:0] m_en = '0, m_st = '0;
  logic [31:0]   m_rd = '0;
  logic          m_irq = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_unit #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_pulse(src_pulse), .irq_o(irq_o)
  );

  function automatic logic [NS-1:0] next_en(logic [NS-1:0] en, logic we, logic [1:0] a,
                                            logic [31:0] d);
    logic [NS-1:0] j, k;
    j = d[NS-1:0];
    k = d[16 +: NS];
    if (!we || a != 2'd0) return en;
    return (j & ~en) | (~k & en);
  endfunction

  function automatic logic [NS-1:0] next_st(logic [NS-1:0] st, logic [NS-1:0] s, logic we,
                                            logic [1:0] a, logic [31:0] d);
    logic [NS-1:0] c;
    c = (we && a == 2'd2) ? d[NS-1:0] : '0;
    return (st & ~c) | s;
  endfunction

  function automatic logic [31:0] next_rd(logic [31:0] rd, logic re, logic [1:0] a,
                                          logic [NS-1:0] en, logic [NS-1:0] st);
    if (!re) return rd;
    case (a)
      2'd0:    return {{(32-NS){1'b0}}, en};
      2'd1:    return {{(32-NS){1'b0}}, st};
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven at falling edge
  task automatic step();
    @(posedge clk);
    m_irq = |(m_st & m_en);
    m_rd  = next_rd(m_rd, rd_en, rd_addr, m_en, m_st);
    m_st  = next_st(m_st, src_pulse, wr_en, wr_addr, wr_data);
    m_en  = next_en(m_en, wr_en, wr_addr, wr_data);
    @(negedge clk);
    check("R8 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
    check("R9 rd_data", rd_data, m_rd);
    wr_en = 1'b0; rd_en = 1'b0; src_pulse = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    step();
    v = rd_data;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);
    check("R1 rd_data after reset", rd_data, 32'd0);
    rd(2'd0, v); check("R1 enable reset", v, 32'd0);
    rd(2'd1, v); check("R1 status reset", v, 32'd0);

    // R2 set then reset half
    wr(2'd0, 32'h0000_0005); rd(2'd0, v); check("R2 enable set", v, 32'h5);
    wr(2'd0, 32'h0004_0000); rd(2'd0, v); check("R2 enable reset", v, 32'h1);
    wr(2'd0, 32'h0000_0000); rd(2'd0, v); check("R2 zero write no effect", v, 32'h1);
    // R3 toggle
    wr(2'd0, 32'h0003_0003); rd(2'd0, v); check("R3 toggle", v, 32'h2);
    // R4 bit 31 and bit 30
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd0, 32'h8000_0000); rd(2'd0, v); check("R4 bit31 disables user", v, 32'h7FFF);
    wr(2'd0, 32'h4000_0000); rd(2'd0, v); check("R4 bit30 disables done", v, 32'h3FFF);
    // R5 one-cycle pulse is latched and sticks
    src_pulse = 16'h0004; step();
    repeat (3) step();
    rd(2'd1, v); check("R5 status latched", v, 32'h4);
    check("R8 irq high for enabled set source", {31'd0, irq_o}, 32'd1);
    // R10 writes to status and spare address ignored
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R10 status untouched", v, 32'h4);
    rd(2'd0, v); check("R10 enable untouched", v, 32'h3FFF);
    // R6 clear then re-fire
    wr(2'd2, 32'h0000_0004); rd(2'd1, v); check("R6 cleared", v, 32'h0);
    step(); check("R8 irq low after clear", {31'd0, irq_o}, 32'd0);
    src_pulse = 16'h0004; step(); rd(2'd1, v); check("R6 re-latch", v, 32'h4);
    // R7 pulse with clear
    src_pulse = 16'h0004; wr(2'd2, 32'h0000_0004);
    rd(2'd1, v); check("R7 event beats clear", v, 32'h4);
    // R8 disabled source: no irq
    src_pulse = 16'h8000; wr(2'd2, 32'h0000_0004);
    step(); step(); check("R8 disabled user source no irq", {31'd0, irq_o}, 32'd0);
    rd(2'd1, v); check("R5 user status latched while disabled", v, 32'h8000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      src_pulse = ($urandom_range(0, 3) == 0) ? NS'($urandom & $urandom & $urandom) : '0;
      if (r < 4) begin
        wr_en = 1'b1; wr_addr = 2'($urandom_range(0, 3));
        wr_data = (r == 0) ? {$urandom_range(0, 65535) & 32'hFFFF} * 32'h0001_0001
                           : $urandom & $urandom;
      end
      if (r > 3) begin
        rd_en = 1'b1; rd_addr = 2'($urandom_range(0, 3));
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule